// File: doc/BRIEF.md
# Processor Idle Power-State Controller

This block steps a processor core through four idle levels: Run, Grant (clock-stopped but still bus-aware), Sleep and Deep Sleep. It watches three active-low requests (stop-clock, sleep, deep-sleep), a flag that reports whether the bus clock is running, and the synchronous reset. From these it drives clock-enable flags for three clock groups: the core units, the bus and interrupt-controller units, and the PLL. It also drives a flag that allows snoops and interrupts, and a one-cycle request to send a grant acknowledge on the bus.

The levels form a ladder. Each deeper level can only be entered from the level just above it. Each level decides for itself which requests it reacts to. The stop-clock request arrives asynchronously and passes through a flop synchronizer before the state machine sees it. The sleep and deep-sleep requests and the bus-clock flag are sampled directly. A management-interrupt input that is held low when reset is released latches an output-float flag, which stays set until the next reset. All outputs are registered. A two-bit state code exposes the current level.

Top module: `pwr_ladder_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `state_code`=0 (Run), all three clock enables 1, `snoop_accept`=1, `grant_ack`=0 and `out_hiz_en`=0.
- R2: `stopclk_n` passes through SYNC_STAGES (default 2) flops. A low level applied before edge k moves Run to Grant at edge k+2. `grant_ack` is 1 for exactly that one cycle.
- R3: In Grant, `core_clk_en`=0, while `sysbus_clk_en`, `pll_clk_en` and `snoop_accept` are all 1.
- R4: In Grant, a synchronized high on stop-clock returns the block to Run with all enables 1. This has priority over a sleep request seen at the same edge.
- R5: A low `sleep_n` moves Grant to Sleep at the next edge. In Run, `sleep_n` has no effect.
- R6: In Sleep, only `pll_clk_en` is 1. `core_clk_en`, `sysbus_clk_en` and `snoop_accept` are 0.
- R7: In Sleep, stop-clock changes have no effect. A high `sleep_n` returns the block to Grant at the next edge.
- R8: In Sleep, a low `dsleep_n` or a low `bclk_run` moves the block to Deep Sleep at the next edge. This wins over a simultaneous high `sleep_n`.
- R9: In Deep Sleep, all three enables and `snoop_accept` are 0. The block returns to Sleep only at an edge where `dsleep_n`=1 and `bclk_run`=1. `dsleep_n` has no effect in Run or Grant.
- R10: If `mgmt_int_n` is 0 at the first edge with `rst` low after an edge with `rst` high, `out_hiz_en` becomes 1. It then stays 1 until reset.
- R11: `state_code` encodes Run=0, Grant=1, Sleep=2, Deep Sleep=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| stopclk_n | input | 1 | Asynchronous stop-clock request, active low |
| sleep_n | input | 1 | Sleep request, active low |
| dsleep_n | input | 1 | Deep-sleep request, active low |
| bclk_run | input | 1 | High while the bus clock is running |
| mgmt_int_n | input | 1 | Management interrupt, active low, sampled at reset release |
| core_clk_en | output | 1 | Clock enable for core units |
| sysbus_clk_en | output | 1 | Clock enable for bus and interrupt-controller units |
| pll_clk_en | output | 1 | PLL run enable |
| grant_ack | output | 1 | One-cycle request to issue the grant acknowledge |
| snoop_accept | output | 1 | Snoops and interrupts may be accepted |
| out_hiz_en | output | 1 | Request to float all outputs |
| state_code | output | 2 | Current power level |

## Verification
Two pairs of events can fall on the same edge. In Grant, a synchronized stop-clock release can meet a sleep request. In Sleep, a sleep release can meet a deep-sleep request. The bench provokes the first pair by dropping `sleep_n` two cycles after raising `stopclk_n`, so that both reach the state machine together. It provokes the second by changing `sleep_n` and `dsleep_n` in the same cycle. The results are judged against R4 (Run wins) and R8 (Deep Sleep wins), both by directed checks and by the per-cycle reference model, which also covers a long stretch of random stimulus.

// File: rtl/pwr_ladder_pkg.sv
package pwr_ladder_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN   = 2'd0,
    PS_GRANT = 2'd1,
    PS_SLEEP = 2'd2,
    PS_DEEP  = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic core;
    logic sysbus;
    logic pll;
    logic snoop;
  } gate_set_t;

  function automatic gate_set_t gates_for(pwr_state_e s);
    gate_set_t g;
    case (s)
      PS_RUN:   g = '{core: 1'b1, sysbus: 1'b1, pll: 1'b1, snoop: 1'b1};
      PS_GRANT: g = '{core: 1'b0, sysbus: 1'b1, pll: 1'b1, snoop: 1'b1};
      PS_SLEEP: g = '{core: 1'b0, sysbus: 1'b0, pll: 1'b1, snoop: 1'b0};
      default:  g = '{core: 1'b0, sysbus: 1'b0, pll: 1'b0, snoop: 1'b0};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pwr_ladder_fsm.sv
module pwr_ladder_fsm
  import pwr_ladder_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       sleep_req,
  input  logic       deep_req,
  input  logic       bclk_run,
  output pwr_state_e state_q,
  output pwr_state_e state_d,
  output logic       ack_q
);

  logic enter_grant;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN: begin
        if (stop_req) state_d = PS_GRANT;
      end
      PS_GRANT: begin
        if (!stop_req)      state_d = PS_RUN;
        else if (sleep_req) state_d = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (deep_req || !bclk_run) state_d = PS_DEEP;
        else if (!sleep_req)       state_d = PS_GRANT;
      end
      PS_DEEP: begin
        if (!deep_req && bclk_run) state_d = PS_SLEEP;
      end
      default: state_d = PS_RUN;
    endcase
  end

  assign enter_grant = (state_q == PS_RUN) && (state_d == PS_GRANT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_RUN;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= enter_grant;
    end
  end

endmodule

// File: rtl/pwr_gate_reg.sv
module pwr_gate_reg
  import pwr_ladder_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pwr_state_e state_d,
  output gate_set_t  gates_q
);

  always_ff @(posedge clk) begin
    if (rst) gates_q <= gates_for(PS_RUN);
    else     gates_q <= gates_for(state_d);
  end

endmodule

// File: rtl/pwr_hiz_latch.sv
module pwr_hiz_latch (
  input  logic clk,
  input  logic rst,
  input  logic mgmt_int_n,
  output logic hiz_q
);

  logic rst_prev;

  always_ff @(posedge clk) begin
    rst_prev <= rst;
    if (rst)                          hiz_q <= 1'b0;
    else if (rst_prev && !mgmt_int_n) hiz_q <= 1'b1;
  end

endmodule

// File: rtl/pwr_ladder_ctrl.sv
module pwr_ladder_ctrl
  import pwr_ladder_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stopclk_n,
  input  logic               sleep_n,
  input  logic               dsleep_n,
  input  logic               bclk_run,
  input  logic               mgmt_int_n,
  output logic               core_clk_en,
  output logic               sysbus_clk_en,
  output logic               pll_clk_en,
  output logic               grant_ack,
  output logic               snoop_accept,
  output logic               out_hiz_en,
  output logic [STATE_W-1:0] state_code
);

  logic       stop_sync_n;
  pwr_state_e st_q;
  pwr_state_e st_d;
  gate_set_t  gates;

  pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
    .clk (clk),
    .rst (rst),
    .d   (stopclk_n),
    .q   (stop_sync_n)
  );

  pwr_ladder_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .stop_req  (~stop_sync_n),
    .sleep_req (~sleep_n),
    .deep_req  (~dsleep_n),
    .bclk_run  (bclk_run),
    .state_q   (st_q),
    .state_d   (st_d),
    .ack_q     (grant_ack)
  );

  pwr_gate_reg u_gates (
    .clk     (clk),
    .rst     (rst),
    .state_d (st_d),
    .gates_q (gates)
  );

  pwr_hiz_latch u_hiz (
    .clk        (clk),
    .rst        (rst),
    .mgmt_int_n (mgmt_int_n),
    .hiz_q      (out_hiz_en)
  );

  assign core_clk_en   = gates.core;
  assign sysbus_clk_en = gates.sysbus;
  assign pll_clk_en    = gates.pll;
  assign snoop_accept  = gates.snoop;
  assign state_code    = st_q;

endmodule

// File: rtl/pwr_ladder_chk.sv
module pwr_ladder_chk (
  input logic       clk,
  input logic       rst,
  input logic       dsleep_n,
  input logic       bclk_run,
  input logic       core_clk_en,
  input logic       sysbus_clk_en,
  input logic       pll_clk_en,
  input logic       grant_ack,
  input logic       snoop_accept,
  input logic       out_hiz_en,
  input logic [1:0] state_code
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state_code == 2'd0 && core_clk_en && sysbus_clk_en && pll_clk_en
             && snoop_accept && !grant_ack && !out_hiz_en));

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    grant_ack |=> !grant_ack);

  // R2
  ack_in_grant_chk: assert property (@(posedge clk) disable iff (rst)
    grant_ack |-> state_code == 2'd1);

  // R3
  grant_gates_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'd1 |-> (!core_clk_en && sysbus_clk_en && pll_clk_en && snoop_accept));

  // R5
  run_ladder_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'd0 |=> state_code inside {2'd0, 2'd1});

  // R6
  sleep_gates_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'd2 |-> (!core_clk_en && !sysbus_clk_en && pll_clk_en && !snoop_accept));

  // R8
  deep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'd2 && (!dsleep_n || !bclk_run)) |=> state_code == 2'd3);

  // R9
  deep_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'd3 && dsleep_n && bclk_run) |=> state_code == 2'd2);

  // R9
  deep_gates_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'd3 |-> $countones({core_clk_en, sysbus_clk_en, pll_clk_en, snoop_accept}) == 0);

  // R10
  hiz_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    out_hiz_en |=> out_hiz_en);

endmodule

bind pwr_ladder_ctrl pwr_ladder_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .dsleep_n      (dsleep_n),
  .bclk_run      (bclk_run),
  .core_clk_en   (core_clk_en),
  .sysbus_clk_en (sysbus_clk_en),
  .pll_clk_en    (pll_clk_en),
  .grant_ack     (grant_ack),
  .snoop_accept  (snoop_accept),
  .out_hiz_en    (out_hiz_en),
  .state_code    (state_code)
);

// File: tb/sim_pwr_ladder_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_ladder_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stopclk_n = 1'b1, sleep_n = 1'b1, dsleep_n = 1'b1, bclk_run = 1'b1, mgmt_int_n = 1'b1;
  logic core_clk_en, sysbus_clk_en, pll_clk_en, grant_ack, snoop_accept, out_hiz_en;
  logic [1:0] state_code;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;

  pwr_ladder_ctrl u0 (
    .clk(clk), .rst(rst), .stopclk_n(stopclk_n), .sleep_n(sleep_n),
    .dsleep_n(dsleep_n), .bclk_run(bclk_run), .mgmt_int_n(mgmt_int_n),
    .core_clk_en(core_clk_en), .sysbus_clk_en(sysbus_clk_en),
    .pll_clk_en(pll_clk_en), .grant_ack(grant_ack),
    .snoop_accept(snoop_accept), .out_hiz_en(out_hiz_en),
    .state_code(state_code)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Reference model: 0 Run, 1 Grant, 2 Sleep, 3 Deep
  int m_st = 0;
  int m_ack = 0;
  int m_hiz = 0;
  int m_prev_rst = 1;
  int m_pipe[$] = '{1, 1};

  always @(posedge clk) begin
    int prev;
    int seen;
    if (rst) begin
      m_st = 0; m_ack = 0; m_hiz = 0;
      m_pipe = '{1, 1};
    end else begin
      prev = m_st;
      seen = m_pipe.pop_front();
      m_pipe.push_back(int'(stopclk_n));
      case (m_st)
        0: if (seen == 0) m_st = 1;
        1: if (seen == 1) m_st = 0; else if (!sleep_n) m_st = 2;
        2: if (!dsleep_n || !bclk_run) m_st = 3; else if (sleep_n) m_st = 1;
        default: if (dsleep_n && bclk_run) m_st = 2;
      endcase
      m_ack = (prev == 0 && m_st == 1) ? 1 : 0;
      if (m_prev_rst == 1 && !mgmt_int_n) m_hiz = 1;
    end
    m_prev_rst = int'(rst);
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R11 state_code", state_code, m_st);
      chk("R3 core_clk_en", core_clk_en, (m_st == 0) ? 1 : 0);
      chk("R6 sysbus_clk_en", sysbus_clk_en, (m_st <= 1) ? 1 : 0);
      chk("R9 pll_clk_en", pll_clk_en, (m_st != 3) ? 1 : 0);
      chk("R6 snoop_accept", snoop_accept, (m_st <= 1) ? 1 : 0);
      chk("R2 grant_ack", grant_ack, m_ack);
      chk("R10 out_hiz_en", out_hiz_en, m_hiz);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    cmp_en = 1'b1;
    // R1 reset outputs
    chk("R1 state", state_code, 0);
    chk("R1 enables", {core_clk_en, sysbus_clk_en, pll_clk_en, snoop_accept}, 4'hF);
    chk("R1 ack/hiz", {grant_ack, out_hiz_en}, 0);
    rst = 1'b0;
    cyc(2);

    // R5 sleep ignored in Run; R9 deep-sleep ignored in Run
    sleep_n = 1'b0; dsleep_n = 1'b0; cyc(4);
    chk("R5 sleep ignored in Run", state_code, 0);
    chk("R9 deep ignored in Run", core_clk_en, 1);
    sleep_n = 1'b1; dsleep_n = 1'b1; cyc(1);

    // R2 synchronizer latency and ack pulse
    stopclk_n = 1'b0; cyc(2);
    chk("R2 still Run after two edges", state_code, 0);
    cyc(1);
    chk("R2 Grant on third edge", state_code, 1);
    chk("R2 ack pulse", grant_ack, 1);
    cyc(1);
    chk("R2 ack one cycle", grant_ack, 0);
    chk("R3 core off in Grant", core_clk_en, 0);
    chk("R3 bus on in Grant", sysbus_clk_en, 1);

    // R9 deep-sleep ignored in Grant
    dsleep_n = 1'b0; cyc(2);
    chk("R9 deep ignored in Grant", state_code, 1);
    dsleep_n = 1'b1;

    // R4 stop release wins over sleep at the same edge
    stopclk_n = 1'b1; cyc(2);
    sleep_n = 1'b0; cyc(1);
    chk("R4 release beats sleep", state_code, 0);
    chk("R4 enables back on", {core_clk_en, sysbus_clk_en}, 2'b11);
    cyc(3);
    chk("R5 held sleep ignored in Run", state_code, 0);
    sleep_n = 1'b1;

    // R5 Grant -> Sleep
    stopclk_n = 1'b0; cyc(4);
    chk("R5 back in Grant", state_code, 1);
    sleep_n = 1'b0; cyc(1);
    chk("R5 Sleep entered", state_code, 2);
    chk("R6 only PLL on", {core_clk_en, sysbus_clk_en, pll_clk_en, snoop_accept}, 4'b0010);

    // R7 stop-clock ignored in Sleep
    stopclk_n = 1'b1; cyc(5);
    chk("R7 stop release ignored in Sleep", state_code, 2);
    stopclk_n = 1'b0; cyc(3);

    // R8 deep-sleep wins over sleep release at the same edge
    sleep_n = 1'b1; dsleep_n = 1'b0; cyc(1);
    chk("R8 deep beats wake", state_code, 3);
    chk("R9 all off in Deep", {core_clk_en, sysbus_clk_en, pll_clk_en, snoop_accept}, 0);
    sleep_n = 1'b0;
    bclk_run = 1'b0; dsleep_n = 1'b1; cyc(2);
    chk("R9 stays Deep while bus clock stopped", state_code, 3);
    bclk_run = 1'b1; cyc(1);
    chk("R9 exit to Sleep", state_code, 2);
    bclk_run = 1'b0; cyc(1);
    chk("R8 bus clock stop enters Deep", state_code, 3);
    bclk_run = 1'b1; cyc(1);
    sleep_n = 1'b1; cyc(1);
    chk("R7 wake to Grant", state_code, 1);
    stopclk_n = 1'b1; cyc(3);
    chk("R4 back to Run", state_code, 0);

    // R10 float request latched at reset release
    rst = 1'b1; mgmt_int_n = 1'b0; cyc(2);
    rst = 1'b0; cyc(1);
    mgmt_int_n = 1'b1;
    chk("R10 hiz set", out_hiz_en, 1);
    cyc(4);
    chk("R10 hiz held", out_hiz_en, 1);
    rst = 1'b1; cyc(2);
    chk("R1 hiz cleared by reset", out_hiz_en, 0);
    rst = 1'b0; cyc(3);
    chk("R10 no hiz without interrupt", out_hiz_en, 0);

    // Random stretch against the model
    for (int i = 0; i < 3000; i++) begin
      stopclk_n  = ($urandom_range(0, 7) != 0) ? stopclk_n : ~stopclk_n;
      sleep_n    = ($urandom_range(0, 5) != 0) ? sleep_n : ~sleep_n;
      dsleep_n   = ($urandom_range(0, 9) != 0) ? 1'b1 : 1'b0;
      bclk_run   = ($urandom_range(0, 15) != 0) ? 1'b1 : 1'b0;
      mgmt_int_n = ($urandom_range(0, 3) != 0) ? 1'b1 : 1'b0;
      rst        = ($urandom_range(0, 199) == 0) ? 1'b1 : 1'b0;
      cyc(1);
    end
    rst = 1'b0;
    cyc(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule